// File: doc/BRIEF.md
# Buck Regulator Start-Up Sequencer

This block orders the start-up of a buck regulator. A 5-bit voltage-select code is turned into a target reference in millivolts. The block then moves a digital reference from zero up to that target over a fixed 2048-clock ramp. Along the way it releases the low-side driver, the high-side driver, the under-voltage monitor and the power-good flag, each at its own point in the ramp. The analog side (the resistor-ladder DAC, the comparators and the gate drivers) lies outside the block. It reaches the block only as flags and codes.

Two supply-good flags and an inhibit request gate the start. When a supply is lost or inhibit is raised, the block drops back to an idle state with the reference at zero. It begins a fresh ramp as soon as the start conditions return. One reserved select code marks the load socket as empty. That code forces every switch off and holds the block there until the next synchronous reset.

Top module: `ss_seq_ctrl`

## Requirements
- R1: The target in millivolts is 1850 − 25 × `vid` for codes 0 to 30. It spans 1850 mV at code 0 down to 1100 mV at code 30. Once the ramp has finished, `ref_code` equals this target.
- R2: Code 31 (all ones) sets `nocpu` from the next clock onward. While `nocpu` is set, `lo_en`, `hi_en`, `uv_arm` and `pgood` are 0 and `ref_code` is 0. Code 31 overrides supply and inhibit in the same cycle. Only `rst` clears `nocpu`.
- R3: A ramp starts on the first clock at which both supplies are good and inhibit is low. `ref_code` is 0 after that clock. It is floor(target × n / 2048) after n further clocks, and it reaches the target exactly at n = 2048.
- R4: While the block is idle, `lo_en` equals `drv_ok` AND NOT `inhibit`, whatever the value of `core_ok`. During the ramp and after it, `lo_en` is 1.
- R5: `hi_en` is 1 exactly when a ramp is under way or finished and `ref_code` ≥ 1000.
- R6: `uv_arm` is 1 exactly when a ramp is under way or finished and `ref_code` ≥ 800.
- R7: `pgood` is the registered value of `pg_ok`, and only after the ramp has finished. At any other time it is 0.
- R8: No ramp starts unless both `drv_ok` and `core_ok` are 1. If either flag is 0 at a clock, the next cycle shows `hi_en` = 0, `uv_arm` = 0, `pgood` = 0 and `ref_code` = 0.
- R9: Inhibit at a clock forces all enables and `pgood` to 0 in the next cycle. It takes priority over ramp completion in the same cycle. After inhibit is released, a new ramp starts from 0.
- R10: The target is captured when the ramp starts. Later non-reserved changes on `vid` do not move `ref_code` until the next start.
- R11: During and right after `rst`, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_ok | input | 1 | Driver supply above its turn-on level |
| core_ok | input | 1 | Controller supply above its turn-on level |
| inhibit | input | 1 | Shutdown request, all switches off |
| vid | input | 5 | Voltage-select code |
| pg_ok | input | 1 | Output-in-window comparator result |
| lo_en | output | 1 | Low-side driver enable |
| hi_en | output | 1 | High-side switching enable |
| uv_arm | output | 1 | Under-voltage monitor enable |
| ref_code | output | 12 | Reference in millivolts |
| pgood | output | 1 | Power-good flag |
| nocpu | output | 1 | Latched empty-socket shutdown |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is ramp completion and shutdown. The bench runs the ramp until its last step is pending and raises inhibit on exactly that edge. The block must show idle outputs with `pgood` low and must never enter the finished state. The second pair is the reserved select code and a supply loss. The bench applies both in a single cycle and expects `nocpu` to win. It also expects the latch to survive when the code is withdrawn and the supply comes back. A behavioural model run in step with the block judges every cycle of both cases.

// File: rtl/ss_pkg.sv
`timescale 1ns/1ps
package ss_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RAMP  = 2'd1,
    ST_RUN   = 2'd2,
    ST_NOCPU = 2'd3
  } ss_state_e;

endpackage

// File: rtl/ss_vid_decode.sv
`timescale 1ns/1ps
module ss_vid_decode #(
  parameter int VID_W   = 5,
  parameter int REF_W   = 12,
  parameter int VMAX_MV = 1850,
  parameter int STEP_MV = 25
) (
  input  logic [VID_W-1:0] vid,
  output logic [REF_W-1:0] tgt,
  output logic             nocpu_req
);

  // Code all-ones is reserved for the empty-socket condition.
  assign nocpu_req = &vid;

  always_comb begin
    tgt = REF_W'(VMAX_MV - STEP_MV * int'(vid));
  end

endmodule

// File: rtl/ss_ramp.sv
`timescale 1ns/1ps
module ss_ramp #(
  parameter int REF_W     = 12,
  parameter int RAMP_LOG2 = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [REF_W-1:0] tgt,
  output logic             last,
  output logic [REF_W-1:0] ref_nxt
);

  localparam int RAMP_LEN = 1 << RAMP_LOG2;
  localparam int CNT_W    = RAMP_LOG2 + 1;
  localparam int ACC_W    = REF_W + RAMP_LOG2;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [ACC_W-1:0] acc_q, acc_nxt;

  // The accumulator holds target*n; its upper bits are floor(target*n/2^L).
  always_comb begin
    cnt_nxt = cnt_q;
    acc_nxt = acc_q;
    if (clr) begin
      cnt_nxt = '0;
      acc_nxt = '0;
    end else if (step) begin
      cnt_nxt = cnt_q + CNT_W'(1);
      acc_nxt = acc_q + ACC_W'(tgt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      acc_q <= acc_nxt;
    end
  end

  assign last    = (cnt_q == CNT_W'(RAMP_LEN - 1));
  assign ref_nxt = acc_nxt[ACC_W-1:RAMP_LOG2];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(RAMP_LEN)); // R3
  AST_ACC_RISES: assert property (@(posedge clk) disable iff (rst)
    (step && !clr) |=> acc_q >= $past(acc_q)); // R3
  AST_EXACT_LAND: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && last) |=> acc_q[RAMP_LOG2-1:0] == '0); // R3

endmodule

// File: rtl/ss_fsm.sv
`timescale 1ns/1ps
module ss_fsm
  import ss_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      nocpu_req,
  input  logic      supplies_ok,
  input  logic      inhibit,
  input  logic      last,
  output ss_state_e st_nxt,
  output logic      start,
  output logic      step,
  output logic      clr
);

  ss_state_e st_q;

  // Priority: empty socket, then supply/inhibit, then sequencing.
  always_comb begin
    st_nxt = st_q;
    start  = 1'b0;
    step   = 1'b0;
    if (st_q == ST_NOCPU || nocpu_req) begin
      st_nxt = ST_NOCPU;
    end else if (!supplies_ok || inhibit) begin
      st_nxt = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_nxt = ST_RAMP;
          start  = 1'b1;
        end
        ST_RAMP: begin
          step = 1'b1;
          if (last) st_nxt = ST_RUN;
        end
        default: st_nxt = st_q;
      endcase
    end
    clr = start || !(st_nxt == ST_RAMP || st_nxt == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_nxt;
  end

  AST_DROP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_NOCPU && !nocpu_req && !supplies_ok) |=> st_q == ST_IDLE); // R8
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RAMP && $past(st_q) == ST_IDLE) |-> $past(supplies_ok && !inhibit)); // R8
  AST_NOCPU_STICKY: assert property (@(posedge clk) disable iff (rst)
    st_q == ST_NOCPU |=> st_q == ST_NOCPU); // R2

endmodule

// File: rtl/ss_seq_ctrl.sv
`timescale 1ns/1ps
module ss_seq_ctrl
  import ss_pkg::*;
#(
  parameter int VID_W     = 5,
  parameter int REF_W     = 12,
  parameter int RAMP_LOG2 = 11,
  parameter int VMAX_MV   = 1850,
  parameter int STEP_MV   = 25,
  parameter int HI_MV     = 1000,
  parameter int UV_MV     = 800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drv_ok,
  input  logic             core_ok,
  input  logic             inhibit,
  input  logic [VID_W-1:0] vid,
  input  logic             pg_ok,
  output logic             lo_en,
  output logic             hi_en,
  output logic             uv_arm,
  output logic [REF_W-1:0] ref_code,
  output logic             pgood,
  output logic             nocpu
);

  logic [REF_W-1:0] tgt_dec, tgt_q, ref_nxt;
  logic             nocpu_req, start, step, clr, last;
  ss_state_e        st_nxt;
  logic             active_nxt;

  ss_vid_decode #(
    .VID_W(VID_W), .REF_W(REF_W), .VMAX_MV(VMAX_MV), .STEP_MV(STEP_MV)
  ) u_dec (
    .vid(vid), .tgt(tgt_dec), .nocpu_req(nocpu_req)
  );

  ss_fsm u_fsm (
    .clk(clk), .rst(rst), .nocpu_req(nocpu_req),
    .supplies_ok(drv_ok && core_ok), .inhibit(inhibit), .last(last),
    .st_nxt(st_nxt), .start(start), .step(step), .clr(clr)
  );

  // Target is captured once per ramp start.
  always_ff @(posedge clk) begin
    if (rst)        tgt_q <= '0;
    else if (start) tgt_q <= tgt_dec;
  end

  ss_ramp #(.REF_W(REF_W), .RAMP_LOG2(RAMP_LOG2)) u_ramp (
    .clk(clk), .rst(rst), .clr(clr), .step(step), .tgt(tgt_q),
    .last(last), .ref_nxt(ref_nxt)
  );

  assign active_nxt = (st_nxt == ST_RAMP) || (st_nxt == ST_RUN);

  // Outputs registered from next-state values so they align with the state.
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_en    <= 1'b0;
      hi_en    <= 1'b0;
      uv_arm   <= 1'b0;
      ref_code <= '0;
      pgood    <= 1'b0;
      nocpu    <= 1'b0;
    end else begin
      lo_en    <= (st_nxt == ST_IDLE) ? (drv_ok && !inhibit) : active_nxt;
      hi_en    <= active_nxt && (ref_nxt >= REF_W'(HI_MV));
      uv_arm   <= active_nxt && (ref_nxt >= REF_W'(UV_MV));
      ref_code <= ref_nxt;
      pgood    <= (st_nxt == ST_RUN) && pg_ok;
      nocpu    <= (st_nxt == ST_NOCPU);
    end
  end

  AST_NOCPU_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    nocpu |-> (!lo_en && !hi_en && !uv_arm && !pgood && ref_code == '0)); // R2
  AST_HI_AFTER_VALLEY: assert property (@(posedge clk) disable iff (rst)
    hi_en |-> ref_code >= REF_W'(HI_MV)); // R5
  AST_UV_BEFORE_HI: assert property (@(posedge clk) disable iff (rst)
    hi_en |-> uv_arm); // R6
  AST_PG_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
    pgood |-> ref_code == tgt_q); // R7
  AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> (!lo_en && !hi_en && !pgood)); // R9

endmodule

// File: tb/tb_ss_seq_ctrl.sv
`timescale 1ns/1ps
module tb_ss_seq_ctrl;

  localparam int RAMP_N = 2048;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       drv_ok = 1'b0, core_ok = 1'b0, inhibit = 1'b0, pg_ok = 1'b0;
  logic [4:0] vid = 5'd0;
  logic       lo_en, hi_en, uv_arm, pgood, nocpu;
  logic [11:0] ref_code;

  int checks = 0, errors = 0;
  int m_st = 0, m_cnt = 0, m_tgt = 0;
  int e_ref = 0, e_lo = 0, e_pg = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ss_seq_ctrl dut (
    .clk(clk), .rst(rst), .drv_ok(drv_ok), .core_ok(core_ok),
    .inhibit(inhibit), .vid(vid), .pg_ok(pg_ok),
    .lo_en(lo_en), .hi_en(hi_en), .uv_arm(uv_arm),
    .ref_code(ref_code), .pgood(pgood), .nocpu(nocpu)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model: states 0 idle, 1 ramping, 2 finished, 3 empty socket.
  task automatic model_step();
    if (rst) begin
      m_st = 0; m_cnt = 0; m_tgt = 0;
    end else if (m_st == 3 || vid == 5'd31) begin
      m_st = 3;
    end else if (!drv_ok || !core_ok || inhibit) begin
      m_st = 0; m_cnt = 0;
    end else if (m_st == 0) begin
      m_st = 1; m_cnt = 0; m_tgt = 1850 - 25 * int'(vid);
    end else if (m_st == 1) begin
      m_cnt++;
      if (m_cnt == RAMP_N) m_st = 2;
    end
    e_ref = (!rst && (m_st == 1 || m_st == 2)) ? (m_tgt * m_cnt) / RAMP_N : 0;
    if (rst)            e_lo = 0;
    else if (m_st == 0) e_lo = (drv_ok && !inhibit) ? 1 : 0;
    else                e_lo = (m_st == 1 || m_st == 2) ? 1 : 0;
    e_pg = (!rst && m_st == 2 && pg_ok) ? 1 : 0;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(posedge clk);
      #1;
      chk("R3 ref_code", int'(ref_code), e_ref);
      chk("R5 hi_en", int'(hi_en), (e_ref >= 1000 && (m_st == 1 || m_st == 2) && !rst) ? 1 : 0);
      chk("R6 uv_arm", int'(uv_arm), (e_ref >= 800 && (m_st == 1 || m_st == 2) && !rst) ? 1 : 0);
      chk("R4 lo_en", int'(lo_en), e_lo);
      chk("R7 pgood", int'(pgood), e_pg);
      chk("R2 nocpu", int'(nocpu), (!rst && m_st == 3) ? 1 : 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    cyc(3);
    chk("R11 lo_en in reset", int'(lo_en), 0);
    chk("R11 ref_code in reset", int'(ref_code), 0);
    rst = 1'b0;
    cyc(2);
    chk("R11 nocpu after reset", int'(nocpu), 0);

    // R4 discharge with only the driver supply
    drv_ok = 1'b1;
    cyc(3);
    chk("R4 discharge lo_en", int'(lo_en), 1);
    chk("R8 no ramp on one supply", int'(ref_code), 0);
    drv_ok = 1'b0; core_ok = 1'b1;
    cyc(2);
    chk("R4 lo_en needs driver supply", int'(lo_en), 0);

    // R1 full ramp at the top code
    drv_ok = 1'b1; vid = 5'd0;
    cyc(RAMP_N + 3);
    chk("R1 target code 0", int'(ref_code), 1850);
    pg_ok = 1'b1;
    cyc(2);
    chk("R7 pgood follows", int'(pgood), 1);

    // R10 target held after start
    vid = 5'd5;
    cyc(10);
    chk("R10 target held", int'(ref_code), 1850);

    // R9 inhibit and restart
    inhibit = 1'b1;
    cyc(2);
    chk("R9 hi_en off", int'(hi_en), 0);
    chk("R9 lo_en off", int'(lo_en), 0);
    vid = 5'd30; inhibit = 1'b0;
    cyc(500);
    inhibit = 1'b1;
    cyc(1);
    inhibit = 1'b0;
    cyc(2);
    chk("R9 fresh ramp from zero", int'(ref_code), 0);
    cyc(RAMP_N + 2);
    chk("R1 target code 30", int'(ref_code), 1100);

    // R8 core supply loss while finished
    core_ok = 1'b0;
    cyc(1);
    chk("R8 hi_en off on supply loss", int'(hi_en), 0);
    chk("R8 ref_code cleared", int'(ref_code), 0);
    chk("R4 lo_en stays on driver supply", int'(lo_en), 1);

    // Coincidence: inhibit on the edge that would finish the ramp
    core_ok = 1'b1; vid = 5'd15;
    for (int i = 0; i < 5000 && !(m_st == 1 && m_cnt == RAMP_N - 1); i++) cyc(1);
    inhibit = 1'b1;
    cyc(1);
    chk("R9 inhibit beats completion", int'(pgood), 0);
    chk("R9 ref cleared at completion edge", int'(ref_code), 0);
    inhibit = 1'b0;
    cyc(RAMP_N + 2);
    chk("R1 target code 15", int'(ref_code), 1475);

    // Coincidence: reserved code and supply loss together
    vid = 5'd31; core_ok = 1'b0;
    cyc(1);
    chk("R2 reserved code wins", int'(nocpu), 1);
    vid = 5'd3; core_ok = 1'b1;
    cyc(20);
    chk("R2 latch holds", int'(nocpu), 1);
    chk("R2 low side off", int'(lo_en), 0);

    // R11 reset clears the latch, then a normal start
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(3);
    chk("R11 latch cleared", int'(nocpu), 0);
    chk("R3 ramp resumes", int'(lo_en), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule